// File: doc/BRIEF.md
# Serial Configuration Register Loader

This block sits behind a two-wire serial slave front end that has already turned the bit stream into whole bytes. A write transaction arrives as a frame. A `frame_start` strobe opens it and a `frame_end` strobe closes it. Each received byte comes with a one-cycle `byte_valid` strobe. The byte bus carries the first-received bit on `byte_data[7]`.

The first byte of a frame is a device address. The block accepts the frame only if that address matches its own, and ignores the rest of the frame otherwise. The next two bytes are a command code and a byte count, which the block consumes without checking. The bytes after those fill a fixed row of data slots in order. The first six slots land in configuration registers. The next two slots and anything beyond them are discarded.

Downstream clock-generation logic reads the raw register contents and a decoded view of them:
- an operating-mode field with spread-spectrum and all-outputs-high-impedance states,
- a frequency-select code, taken either from the external select pins or from the serial bits,
- active-high per-output clock-disable lines.

Top module: `serial_cfg_loader`

## Requirements
- R1: After a synchronous active-low reset, `cfg_regs` reads 48'hFFFF_FF7F_0F00. Register k sits in bits [8k+7:8k]. Register 0 is 8'h00, register 1 is 8'h0F, register 2 is 8'h7F, and registers 3 to 5 are 8'hFF.
- R2: Data bytes are stored only when the first byte of the frame equals 8'hD2. With any other address, the whole frame leaves every register unchanged.
- R3: In an accepted frame, the 2nd and 3rd bytes are consumed with no effect. The 4th to 9th bytes are written to registers 0 to 5 in that order.
- R4: The 10th and 11th bytes of a frame, and any later bytes, change no register.
- R5: A register written by a byte shows its new value on `cfg_regs` right after the clock edge that samples that byte's `byte_valid`, and not before. No register changes on a cycle without `byte_valid`.
- R6: If a frame ends after only some data bytes, the registers already written keep their new values and the others keep their old ones.
- R7: Mode is register 0 bits [1:0]. 2'b10 raises `spread_en`. 2'b11 raises `outputs_hiz`. Both 2'b00 and the reserved 2'b01 give normal operation, with both flags low. The two flags are never high together.
- R8: When register 0 bit 3 is 0, `freq_sel` equals `pin_freq_sel`. When it is 1, `freq_sel` is {reg0[2], reg0[6], reg0[5], reg0[4]}. `freq_from_serial` mirrors bit 3.
- R9: `clk_disable` is the bitwise inverse of {register 2, register 1}, so a 0 written to a control bit disables its output.
- R10: A `byte_valid` outside a frame (before any `frame_start`, or after `frame_end`) has no effect. So does one in the same cycle as `frame_start` or `frame_end`.
- R11: A `frame_start` inside an open frame restarts byte counting, so the next byte is treated as a new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | One-cycle strobe opening a write frame |
| frame_end | input | 1 | One-cycle strobe closing the frame |
| byte_valid | input | 1 | One-cycle strobe qualifying `byte_data` |
| byte_data | input | 8 | Received byte, first-received bit in bit 7 |
| pin_freq_sel | input | 4 | Frequency code from the external select pins |
| cfg_regs | output | 48 | All six registers, register k in bits [8k+7:8k] |
| spread_en | output | 1 | Spread-spectrum mode selected |
| outputs_hiz | output | 1 | All clock outputs to high impedance |
| freq_from_serial | output | 1 | Frequency code comes from the serial bits |
| freq_sel | output | 4 | Effective frequency-select code |
| clk_disable | output | 16 | Active-high disable per output, from registers 2 and 1 |

## Verification
The bench goes after the frame-position boundaries:
- It checks the 4th byte against the 3rd and the 9th byte against the 10th. A design off by one there shifts every register or writes a discarded slot into register 5.
- It sends a frame with a near-miss address, 8'hD3. A loose comparison would corrupt all registers.
- It sends a truncated frame, bytes before a frame opens and after it closes, and a restart in mid-frame. Each of these exposes a position counter that is not cleared or not gated.

It steps register 0 through all four mode codes. A decoder that treats the reserved code as spread spectrum, or inverts the disable polarity, shows up as a mismatch on the decoded outputs.

// File: rtl/scl_pkg.sv
package scl_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [1:0] {
      MODE_NORMAL = 2'b00,
      MODE_RSVD   = 2'b01,
      MODE_SPREAD = 2'b10,
      MODE_HIZ    = 2'b11
   } op_mode_e;
endpackage

// File: rtl/scl_frame_seq.sv
module scl_frame_seq
   import scl_pkg::*;
#(
   parameter int FIRST_POS = 3,
   parameter int NUM_SLOTS = 8,
   parameter int NUM_REGS  = 6,
   parameter logic [BYTE_W-1:0] DEV_ADDR = 8'hD2,
   localparam int POS_LAST = FIRST_POS + NUM_SLOTS,
   localparam int POS_W    = $clog2(POS_LAST + 1),
   localparam int SLOT_W   = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic              frame_end,
   input  logic              byte_valid,
   input  logic [BYTE_W-1:0] byte_data,
   output logic              wr_en,
   output logic [SLOT_W-1:0] wr_slot
);
   localparam logic [POS_W-1:0] P_FIRST = POS_W'(FIRST_POS);
   localparam logic [POS_W-1:0] P_STOP  = POS_W'(FIRST_POS + NUM_REGS);
   localparam logic [POS_W-1:0] P_LAST  = POS_W'(POS_LAST);

   logic             in_frame;
   logic             addr_hit;
   logic [POS_W-1:0] pos;
   logic             take;
   logic [POS_W-1:0] rel;

   // a byte counts only inside a frame and away from framing strobes
   assign take = byte_valid && in_frame && !frame_start && !frame_end;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_frame <= 1'b0;
         addr_hit <= 1'b0;
         pos      <= '0;
      end else if (frame_start) begin
         in_frame <= 1'b1;
         addr_hit <= 1'b0;
         pos      <= '0;
      end else if (frame_end) begin
         in_frame <= 1'b0;
      end else if (take) begin
         if (pos == '0) addr_hit <= (byte_data == DEV_ADDR);
         if (pos != P_LAST) pos <= pos + 1'b1;
      end
   end

   assign rel     = pos - P_FIRST;
   assign wr_en   = take && addr_hit && (pos >= P_FIRST) && (pos < P_STOP);
   assign wr_slot = rel[SLOT_W-1:0];
endmodule

// File: rtl/scl_regfile.sv
module scl_regfile
   import scl_pkg::*;
#(
   parameter int NUM_REGS = 6,
   parameter logic [NUM_REGS*BYTE_W-1:0] REG_DEFAULTS = '0,
   localparam int SLOT_W = $clog2(NUM_REGS)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [SLOT_W-1:0]          wr_slot,
   input  logic [BYTE_W-1:0]          wr_data,
   output logic [NUM_REGS*BYTE_W-1:0] regs_flat
);
   for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      logic [BYTE_W-1:0] r;
      always_ff @(posedge clk) begin
         if (!rst_n)
            r <= REG_DEFAULTS[g*BYTE_W +: BYTE_W];
         else if (wr_en && (wr_slot == SLOT_W'(g)))
            r <= wr_data;
      end
      assign regs_flat[g*BYTE_W +: BYTE_W] = r;
   end
endmodule

// File: rtl/scl_decode.sv
module scl_decode
   import scl_pkg::*;
#(
   parameter int SEL_W = 4,
   parameter int DIS_W = 16
) (
   input  logic [6:0]       ctl_byte,
   input  logic [DIS_W-1:0] enable_bits,
   input  logic [SEL_W-1:0] pin_sel,
   output logic             spread_en,
   output logic             outputs_hiz,
   output logic             from_serial,
   output logic [SEL_W-1:0] sel_out,
   output logic [DIS_W-1:0] disable_out
);
   op_mode_e mode;

   assign mode = op_mode_e'(ctl_byte[1:0]);

   always_comb begin
      spread_en   = 1'b0;
      outputs_hiz = 1'b0;
      unique case (mode)
         MODE_SPREAD: spread_en   = 1'b1;
         MODE_HIZ:    outputs_hiz = 1'b1;
         default:     ; // normal and reserved behave alike
      endcase
   end

   assign from_serial = ctl_byte[3];
   assign sel_out     = from_serial ? {ctl_byte[2], ctl_byte[6:4]} : pin_sel;
   assign disable_out = ~enable_bits;
endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
   import scl_pkg::*;
#(
   parameter int NUM_REGS  = 6,
   parameter int NUM_SLOTS = 8,
   parameter int FIRST_POS = 3,
   parameter int SEL_W     = 4,
   parameter logic [BYTE_W-1:0] DEV_ADDR = 8'hD2,
   parameter logic [NUM_REGS*BYTE_W-1:0] REG_DEFAULTS = 48'hFFFF_FF7F_0F00,
   localparam int REGS_W = NUM_REGS * BYTE_W,
   localparam int DIS_W  = 2 * BYTE_W,
   localparam int SLOT_W = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic              frame_end,
   input  logic              byte_valid,
   input  logic [7:0]        byte_data,
   input  logic [SEL_W-1:0]  pin_freq_sel,
   output logic [REGS_W-1:0] cfg_regs,
   output logic              spread_en,
   output logic              outputs_hiz,
   output logic              freq_from_serial,
   output logic [SEL_W-1:0]  freq_sel,
   output logic [DIS_W-1:0]  clk_disable
);
   initial begin
      assert (NUM_REGS >= 3) else $error("need control and two enable registers");
      assert (NUM_SLOTS >= NUM_REGS) else $error("slots must cover registers");
      assert (FIRST_POS >= 1) else $error("address must precede data");
      assert (SEL_W == 4) else $error("serial code carries four bits");
   end

   logic              wr_en;
   logic [SLOT_W-1:0] wr_slot;

   scl_frame_seq #(
      .FIRST_POS (FIRST_POS),
      .NUM_SLOTS (NUM_SLOTS),
      .NUM_REGS  (NUM_REGS),
      .DEV_ADDR  (DEV_ADDR)
   ) i_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_start (frame_start),
      .frame_end   (frame_end),
      .byte_valid  (byte_valid),
      .byte_data   (byte_data),
      .wr_en       (wr_en),
      .wr_slot     (wr_slot)
   );

   scl_regfile #(
      .NUM_REGS     (NUM_REGS),
      .REG_DEFAULTS (REG_DEFAULTS)
   ) i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_slot   (wr_slot),
      .wr_data   (byte_data),
      .regs_flat (cfg_regs)
   );

   scl_decode #(
      .SEL_W (SEL_W),
      .DIS_W (DIS_W)
   ) i_dec (
      .ctl_byte    (cfg_regs[6:0]),
      .enable_bits (cfg_regs[3*BYTE_W-1:BYTE_W]),
      .pin_sel     (pin_freq_sel),
      .spread_en   (spread_en),
      .outputs_hiz (outputs_hiz),
      .from_serial (freq_from_serial),
      .sel_out     (freq_sel),
      .disable_out (clk_disable)
   );
endmodule

// File: rtl/scl_loader_chk.sv
module scl_loader_chk #(
   parameter int NUM_REGS = 6
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  byte_valid,
   input logic [NUM_REGS*8-1:0] cfg_regs,
   input logic [3:0]            pin_freq_sel,
   input logic                  spread_en,
   input logic                  outputs_hiz,
   input logic                  freq_from_serial,
   input logic [3:0]            freq_sel,
   input logic [15:0]           clk_disable
);
   logic [NUM_REGS*8-1:0] prev_regs;
   logic                  prev_ok;
   logic                  prev_bv;
   logic [NUM_REGS-1:0]   chg;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_ok <= 1'b0;
         prev_bv <= 1'b0;
         prev_regs <= '0;
      end else begin
         prev_ok <= 1'b1;
         prev_bv <= byte_valid;
         prev_regs <= cfg_regs;
      end
   end

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_chg
      assign chg[g] = prev_regs[g*8 +: 8] != cfg_regs[g*8 +: 8];
   end

   assert_one_reg_per_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
      prev_ok |-> $onehot0(chg));
   assert_change_needs_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (prev_ok && (chg != '0)) |-> prev_bv);
   assert_modes_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(spread_en && outputs_hiz));
   assert_hiz_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
      outputs_hiz == (cfg_regs[1:0] == 2'b11));
   assert_pins_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !freq_from_serial |-> (freq_sel == pin_freq_sel));
   assert_serial_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
      freq_from_serial |-> (freq_sel == {cfg_regs[2], cfg_regs[6:4]}));
   assert_disable_polarity_R9: assert property (@(posedge clk) disable iff (!rst_n)
      clk_disable == ~cfg_regs[23:8]);
endmodule

bind serial_cfg_loader scl_loader_chk #(.NUM_REGS(NUM_REGS)) i_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .byte_valid       (byte_valid),
   .cfg_regs         (cfg_regs),
   .pin_freq_sel     (pin_freq_sel),
   .spread_en        (spread_en),
   .outputs_hiz      (outputs_hiz),
   .freq_from_serial (freq_from_serial),
   .freq_sel         (freq_sel),
   .clk_disable      (clk_disable)
);

// File: tb/test_serial_cfg_loader.sv
`timescale 1ns/1ps
module test_serial_cfg_loader;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_start = 1'b0, frame_end = 1'b0, byte_valid = 1'b0;
   logic [7:0]  byte_data = 8'h00;
   logic [3:0]  pin_freq_sel = 4'hA;
   logic [47:0] cfg_regs;
   logic        spread_en, outputs_hiz, freq_from_serial;
   logic [3:0]  freq_sel;
   logic [15:0] clk_disable;

   always #2 clk = ~clk;

   serial_cfg_loader i_serial_cfg_loader (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_end(frame_end),
      .byte_valid(byte_valid), .byte_data(byte_data), .pin_freq_sel(pin_freq_sel),
      .cfg_regs(cfg_regs), .spread_en(spread_en), .outputs_hiz(outputs_hiz),
      .freq_from_serial(freq_from_serial), .freq_sel(freq_sel), .clk_disable(clk_disable)
   );

   int n_checks = 0;
   int n_fail = 0;
   int cycles = 0;
   bit compare_on = 1'b0;
   bit done = 1'b0;

   // behavioural reference model
   logic [7:0] m_reg [6];
   bit         m_open, m_ok;
   int         m_pos;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_reg[0] = 8'h00; m_reg[1] = 8'h0F; m_reg[2] = 8'h7F;
         m_reg[3] = 8'hFF; m_reg[4] = 8'hFF; m_reg[5] = 8'hFF;
         m_open = 0; m_ok = 0; m_pos = 0;
      end else if (frame_start) begin
         m_open = 1; m_ok = 0; m_pos = 0;
      end else if (frame_end) begin
         m_open = 0;
      end else if (byte_valid && m_open) begin
         if (m_pos == 0) m_ok = (byte_data == 8'hD2);
         else if (m_ok && m_pos >= 3 && m_pos <= 8) m_reg[m_pos-3] = byte_data;
         m_pos++;
      end
   end

   function automatic logic [47:0] model_regs();
      return {m_reg[5], m_reg[4], m_reg[3], m_reg[2], m_reg[1], m_reg[0]};
   endfunction

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      #1;
      if (compare_on && rst_n) begin
         logic [1:0] md;
         logic [3:0] fs;
         md = m_reg[0][1:0];
         fs = m_reg[0][3] ? {m_reg[0][2], m_reg[0][6:4]} : pin_freq_sel;
         check(cfg_regs === model_regs(), "R3 register image", cfg_regs, model_regs());
         check(spread_en === (md == 2'b10), "R7 spread", spread_en, md == 2'b10);
         check(outputs_hiz === (md == 2'b11), "R7 hiz", outputs_hiz, md == 2'b11);
         check(freq_sel === fs, "R8 freq_sel", freq_sel, fs);
         check(clk_disable === ~{m_reg[2], m_reg[1]}, "R9 disable", clk_disable, ~{m_reg[2], m_reg[1]});
      end
   end

   task automatic finish_up();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done) begin
         n_fail++;
         $display("FAIL watchdog actual=%0d expected<150000", cycles);
         finish_up();
      end
   end

   task automatic strobe_start();
      @(negedge clk) frame_start = 1'b1;
      @(negedge clk) frame_start = 1'b0;
   endtask

   task automatic strobe_end();
      @(negedge clk) frame_end = 1'b1;
      @(negedge clk) frame_end = 1'b0;
   endtask

   task automatic put_byte(input logic [7:0] b);
      @(negedge clk); byte_valid = 1'b1; byte_data = b;
      @(negedge clk); byte_valid = 1'b0;
   endtask

   task automatic send_frame(input logic [7:0] addr, input logic [7:0] data [$]);
      strobe_start();
      put_byte(addr);
      put_byte(8'h00);
      put_byte(8'(data.size()));
      foreach (data[i]) put_byte(data[i]);
      strobe_end();
   endtask

   initial begin
      logic [47:0] snap;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      // R1 reset state
      check(cfg_regs === 48'hFFFF_FF7F_0F00, "R1 reset regs", cfg_regs, 48'hFFFF_FF7F_0F00);
      check(!spread_en && !outputs_hiz && !freq_from_serial, "R1 reset decode",
            {spread_en, outputs_hiz, freq_from_serial}, 0);
      check(clk_disable === 16'h80F0, "R1 R9 reset disable", clk_disable, 16'h80F0);
      compare_on = 1'b1;

      // R10 bytes before any frame
      put_byte(8'hD2); put_byte(8'h00); put_byte(8'h00); put_byte(8'h33);
      #1 check(cfg_regs === 48'hFFFF_FF7F_0F00, "R10 pre-frame bytes", cfg_regs, 48'hFFFF_FF7F_0F00);

      // R3 R4 full frame with trailing slots and extra byte
      send_frame(8'hD2, '{8'h5A, 8'h05, 8'h3C, 8'h11, 8'h22, 8'h33, 8'hEE, 8'hEE, 8'h77});
      #1;
      check(cfg_regs === 48'h3322_113C_055A, "R3 R4 full frame", cfg_regs, 48'h3322_113C_055A);
      check(spread_en === 1'b1 && outputs_hiz === 1'b0, "R7 spread code", spread_en, 1);
      check(freq_sel === 4'h5 && freq_from_serial, "R8 serial code", freq_sel, 4'h5);
      check(clk_disable === 16'hC3FA, "R9 disable image", clk_disable, 16'hC3FA);

      // R2 near-miss address
      send_frame(8'hD3, '{8'h03, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00});
      #1 check(cfg_regs === 48'h3322_113C_055A, "R2 wrong address", cfg_regs, 48'h3322_113C_055A);

      // R5 R6 truncated frame with timing probe
      strobe_start(); put_byte(8'hD2); put_byte(8'h01); put_byte(8'h02);
      @(negedge clk); byte_valid = 1'b1; byte_data = 8'h03; #1;
      check(cfg_regs[7:0] === 8'h5A, "R5 before edge", cfg_regs[7:0], 8'h5A);
      @(negedge clk); byte_valid = 1'b0; #1;
      check(cfg_regs[7:0] === 8'h03, "R5 after edge", cfg_regs[7:0], 8'h03);
      put_byte(8'hFF);
      strobe_end();
      #1;
      check(cfg_regs === 48'h3322_113C_FF03, "R6 truncated frame", cfg_regs, 48'h3322_113C_FF03);
      check(outputs_hiz === 1'b1 && spread_en === 1'b0, "R7 hiz code", outputs_hiz, 1);

      // R10 bytes after frame end
      put_byte(8'hD2); put_byte(8'h44);
      #1 check(cfg_regs === 48'h3322_113C_FF03, "R10 post-frame bytes", cfg_regs, 48'h3322_113C_FF03);

      // R7 reserved code, R8 pin path
      send_frame(8'hD2, '{8'h71});
      pin_freq_sel = 4'h6; #1;
      check(!spread_en && !outputs_hiz, "R7 reserved is normal", {spread_en, outputs_hiz}, 0);
      check(freq_sel === 4'h6 && !freq_from_serial, "R8 pin path", freq_sel, 4'h6);
      send_frame(8'hD2, '{8'h00});
      #1 check(!spread_en && !outputs_hiz, "R7 normal code", {spread_en, outputs_hiz}, 0);

      // R11 restart inside open frame
      strobe_start(); put_byte(8'hD2); put_byte(8'h00);
      strobe_start(); put_byte(8'hD2); put_byte(8'h00); put_byte(8'h01); put_byte(8'h4E);
      strobe_end();
      #1 check(cfg_regs[7:0] === 8'h4E, "R11 restart", cfg_regs[7:0], 8'h4E);

      // R10 byte coincident with frame_start is not an address
      @(negedge clk); frame_start = 1'b1; byte_valid = 1'b1; byte_data = 8'hD2;
      @(negedge clk); frame_start = 1'b0; byte_valid = 1'b0;
      snap = cfg_regs;
      put_byte(8'h00); put_byte(8'h00); put_byte(8'h09); put_byte(8'h08);
      strobe_end();
      #1 check(cfg_regs === snap, "R10 byte with start", cfg_regs, snap);

      repeat (3) @(negedge clk);
      finish_up();
   end
endmodule